// File: doc/BRIEF.md
# Four-Channel Line Driver and Transmit-Clock Control Register

This block holds the line-control settings of four serial channels and turns them, together with each channel's request-to-send (RTS) input, into the enables for the line transceivers. For each channel, the receiver, the data driver and the transmit-clock output driver can each be set to stay on all the time. Each one can instead follow RTS. When they follow RTS, the drivers are on only while RTS is asserted and the receiver is on only while RTS is released. On a two-wire RS-485 bus this keeps a node from hearing its own transmission, and it releases the bus when the node is idle.

The same register bank sets the transmit-clock routing of each channel. An external clock input path can be joined to the controller's transmit-clock pin, and so can a clock output driver path. An interlock keeps the external input path away from the pin whenever the controller drives that pin as an output. If software asks for that forbidden routing, the block records the request in a sticky flag. The bank is reached through a simple byte-wide local-bus port with a write strobe. Read data comes from the address registered at the previous clock edge.

Top module: `rs485_line_ctl`

## Requirements
- R1: Byte 0 holds the modes of channels 1 and 2, and byte 1 holds the modes of channels 3 and 4. The lower-numbered channel of a pair uses bits 2:0 and the other uses bits 6:4. Within a field, bit +0 is the receiver mode, bit +1 the data-driver mode and bit +2 the clock-driver mode. A write stores the field and a read returns it.
- R2: A receiver with mode bit 1 is always enabled. With mode bit 0 it is enabled only while that channel's RTS is low.
- R3: A data driver with mode bit 1 is always enabled. With mode bit 0 it is enabled only while RTS is high.
- R4: A clock output driver with mode bit 1 is always enabled. With mode bit 0 it is enabled only while RTS is high.
- R5: In byte 2, channel n (0-based) uses bit 2n for the external-input select and bit 2n+1 for the clock-output select. A 0 in either bit joins that path to the transmit clock and a 1 isolates it. Byte 2 reads back as written. The clock-output path is joined exactly when its bit is 0.
- R6: After reset, bytes 0 and 1 read 0x77, byte 2 reads 0x55 and byte 3 reads 0x00. Every receiver and driver is then always enabled, every external-input path is isolated and every clock-output path is joined.
- R7: The external-input path is joined only when its select bit is 0 and the channel's clock-direction input is 0, meaning the pin is an input. With the pin as an input and both paths joined, both link outputs are high, so the external clock is passed out on the clock output.
- R8: Bit 7 of byte 3 is a flag. It becomes 1 after any clock edge at which a channel has its external-input select at 0 while its clock-direction input is 1. It then stays 1 until reset. Bits 6:0 of byte 3 read 0.
- R9: Bits 3 and 7 of bytes 0 and 1 always read 0. Writes to those bits, and any write to byte 3, change nothing.
- R10: The read data shows the byte at the address sampled at the latest clock edge, taken from the current register contents. After a write edge, a read of the same address shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Byte address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the registered address |
| rts | input | 4 | Per-channel RTS, 1 = asserted |
| tclk_dir_out | input | 4 | Per-channel controller clock direction, 1 = pin is an output |
| rx_en | output | 4 | Receiver enable |
| tx_drv_en | output | 4 | Data driver enable |
| clk_drv_en | output | 4 | Transmit-clock output driver enable |
| st_link | output | 4 | External clock input path joined to the transmit clock |
| tt_link | output | 4 | Clock output path joined to the transmit clock |

## Verification
The enables and links are combinational from the stored bytes and the live RTS and direction inputs. A wrong stored mode or select bit therefore shows on a pin in the same cycle that RTS or direction makes it matter, and on the read port one edge after its address is presented. A lost or self-clearing conflict flag appears only when byte 3 is read. For this reason the flag is read back both long after its cause has gone and after a reset. The interlock is checked by changing the direction input while the external path is requested, and watching the link pin drop with no clock edge.

// File: rtl/lc_pkg.sv
// Shared types for the line-control register bank.
// Assumes byte-wide bus data; field layouts follow the register map.
package lc_pkg;
    localparam int BYTE_W = 8;

    // Per-channel mode field, bit 0 = receiver, 1 = data driver, 2 = clock driver
    typedef struct packed {
        logic clk_on;
        logic tx_on;
        logic rx_on;
    } mode_t;

    // Per-channel clock routing request, bit 0 = external input, 1 = clock output
    typedef struct packed {
        logic tt_off;
        logic st_off;
    } route_t;

    localparam mode_t  MODE_RST  = '{clk_on: 1'b1, tx_on: 1'b1, rx_on: 1'b1};
    localparam route_t ROUTE_RST = '{tt_off: 1'b0, st_off: 1'b1};
endpackage

// File: rtl/lc_chan_gate.sv
// Turns one channel's mode field and RTS into transceiver enables.
// Assumes RTS is synchronous to clk; outputs are purely combinational.
module lc_chan_gate
    import lc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  rts,
    output logic  rx_en,
    output logic  tx_en,
    output logic  ck_en
);
    // Gate each enable by RTS unless its mode bit forces it on
    always_comb begin
        rx_en = mode.rx_on | ~rts;
        tx_en = mode.tx_on | rts;
        ck_en = mode.clk_on | rts;
    end

    // R2
    rx_idle_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> rx_en);
    // R3
    tx_talk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts |-> tx_en);
    // R4
    ck_talk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts |-> ck_en);
endmodule

// File: rtl/lc_clk_route.sv
// Applies one channel's clock routing request with the direction interlock.
// Assumes tclk_is_out is 1 when the controller drives its clock pin.
module lc_clk_route
    import lc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  route_t req,
    input  logic   tclk_is_out,
    output logic   st_link,
    output logic   tt_link,
    output logic   conflict
);
    // Join paths on request; hold the external input off while the pin drives
    always_comb begin
        st_link  = ~req.st_off & ~tclk_is_out;
        tt_link  = ~req.tt_off;
        conflict = ~req.st_off & tclk_is_out;
    end

    // R7
    no_drive_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tclk_is_out |-> !st_link);
    // R7
    isolated_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req.st_off |-> !st_link);
endmodule

// File: rtl/lc_regbank.sv
// Byte-addressed storage for mode and routing fields plus the sticky flag.
// Assumes NCH is a multiple of four; reads use the address registered last edge.
module lc_regbank
    import lc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              conflict_any,
    output mode_t             mode_q  [NCH],
    output route_t            route_q [NCH],
    output logic [BYTE_W-1:0] rdata
);
    localparam int N_MODE  = NCH / 2;
    localparam int N_ROUTE = NCH / 4;
    localparam int N_BYTES = N_MODE + N_ROUTE + 1;
    localparam int STAT_AD = N_BYTES - 1;

    logic [AW-1:0]     addr_q;
    logic              flag_q;
    logic [BYTE_W-1:0] img [N_BYTES];

    // Register the read address
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr;
    end

    // Sticky conflict flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_q | conflict_any;
    end

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            localparam int MB = i / 2;
            localparam int MN = i % 2;
            localparam int RB = N_MODE + i / 4;
            localparam int RS = i % 4;

            // Store this channel's mode field on a write to its byte
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_q[i] <= MODE_RST;
                else if (wr_en && addr == AW'(MB))
                    mode_q[i] <= mode_t'(wdata[MN*4 +: 3]);
            end

            // Store this channel's routing request on a write to its byte
            always_ff @(posedge clk) begin
                if (!rst_n)
                    route_q[i] <= ROUTE_RST;
                else if (wr_en && addr == AW'(RB))
                    route_q[i] <= route_t'(wdata[RS*2 +: 2]);
            end

            // R6
            rst_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (mode_q[i] == MODE_RST && route_q[i] == ROUTE_RST));
        end

        for (i = 0; i < N_MODE; i++) begin : g_mimg
            // Mode byte image with the spare bits tied low
            assign img[i] = {1'b0, mode_q[2*i+1], 1'b0, mode_q[2*i]};
        end

        for (i = 0; i < N_ROUTE; i++) begin : g_rimg
            // Routing byte image, four channels per byte
            assign img[N_MODE+i] = {route_q[4*i+3], route_q[4*i+2],
                                    route_q[4*i+1], route_q[4*i]};
        end
    endgenerate

    // Status byte image
    assign img[STAT_AD] = {flag_q, 7'b0};

    // Read mux from the registered address
    always_comb begin
        if (int'(addr_q) < N_BYTES) rdata = img[addr_q];
        else                        rdata = '0;
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(flag_q));
    // R8
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_q) == STAT_AD) |-> (rdata[6:0] == 7'b0));
    // R9
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_q) < N_MODE) |-> (rdata[3] == 1'b0 && rdata[7] == 1'b0));
    // R10
    read_follows_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_q) == STAT_AD) |-> (rdata[7] == flag_q));
endmodule

// File: rtl/rs485_line_ctl.sv
// Top of the line-control block: register bank, per-channel gating and
// per-channel clock routing. Assumes all inputs are synchronous to clk.
module rs485_line_ctl
    import lc_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(NCH / 2 + NCH / 4 + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    rts,
    input  logic [NCH-1:0]    tclk_dir_out,
    output logic [NCH-1:0]    rx_en,
    output logic [NCH-1:0]    tx_drv_en,
    output logic [NCH-1:0]    clk_drv_en,
    output logic [NCH-1:0]    st_link,
    output logic [NCH-1:0]    tt_link
);
    mode_t          mode_q  [NCH];
    route_t         route_q [NCH];
    logic [NCH-1:0] conflict;

    lc_regbank #(.NCH(NCH), .AW(AW)) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (bus_addr),
        .wr_en        (bus_wr),
        .wdata        (bus_wdata),
        .conflict_any (|conflict),
        .mode_q       (mode_q),
        .route_q      (route_q),
        .rdata        (bus_rdata)
    );

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            lc_chan_gate i_gate (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (mode_q[i]),
                .rts   (rts[i]),
                .rx_en (rx_en[i]),
                .tx_en (tx_drv_en[i]),
                .ck_en (clk_drv_en[i])
            );

            lc_clk_route i_route (
                .clk         (clk),
                .rst_n       (rst_n),
                .req         (route_q[i]),
                .tclk_is_out (tclk_dir_out[i]),
                .st_link     (st_link[i]),
                .tt_link     (tt_link[i]),
                .conflict    (conflict[i])
            );
        end
    endgenerate
endmodule

// File: tb/test_rs485_line_ctl.sv
module test_rs485_line_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] rts = '0, tclk_dir_out = '0;
    logic [3:0] rx_en, tx_drv_en, clk_drv_en, st_link, tt_link;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Model state built from the requirements
    logic [7:0] m_b0, m_b1, m_b2;
    logic       m_flag;

    always #10 clk = ~clk;

    rs485_line_ctl i_rs485_line_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rts(rts),
        .tclk_dir_out(tclk_dir_out), .rx_en(rx_en), .tx_drv_en(tx_drv_en),
        .clk_drv_en(clk_drv_en), .st_link(st_link), .tt_link(tt_link)
    );

    // Stimulus row: addr, wdata, rts, dir, expected read byte
    localparam logic [25:0] VEC [10] = '{
        {2'd0, 8'h00, 4'b0000, 4'b0000, 8'h00},
        {2'd0, 8'hFF, 4'b0011, 4'b0000, 8'h77},
        {2'd1, 8'h12, 4'b1010, 4'b0000, 8'h12},
        {2'd1, 8'hA5, 4'b0101, 4'b0000, 8'h25},
        {2'd2, 8'h00, 4'b0000, 4'b0000, 8'h00},
        {2'd2, 8'hAA, 4'b0000, 4'b0000, 8'hAA},
        {2'd2, 8'h00, 4'b0100, 4'b0100, 8'h00},
        {2'd3, 8'hFF, 4'b0000, 4'b0000, 8'h80},
        {2'd2, 8'h55, 4'b0000, 4'b1111, 8'h55},
        {2'd0, 8'h88, 4'b1111, 4'b0000, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] st_req();
        return ~{m_b2[6], m_b2[4], m_b2[2], m_b2[0]};
    endfunction

    function automatic logic [2:0] fld(input int ch);
        logic [7:0] b;
        b = (ch < 2) ? m_b0 : m_b1;
        return b[(ch % 2) * 4 +: 3];
    endfunction

    task automatic model_reset();
        m_b0 = 8'h77; m_b1 = 8'h77; m_b2 = 8'h55; m_flag = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One bus cycle, then sample at the following falling edge
    task automatic bus_cycle(input logic [1:0] a, input logic wr, input logic [7:0] d);
        bus_addr = a; bus_wr = wr; bus_wdata = d;
        m_flag = m_flag | |(st_req() & tclk_dir_out);
        if (wr) begin
            case (a)
                2'd0: m_b0 = d & 8'h77;
                2'd1: m_b1 = d & 8'h77;
                2'd2: m_b2 = d;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_pins(input string tag);
        logic [3:0] erx, etx, eck, est, ett;
        for (int c = 0; c < 4; c++) begin
            logic [2:0] f;
            f = fld(c);
            erx[c] = f[0] | ~rts[c];
            etx[c] = f[1] | rts[c];
            eck[c] = f[2] | rts[c];
            est[c] = ~m_b2[2*c] & ~tclk_dir_out[c];
            ett[c] = ~m_b2[2*c+1];
        end
        chk({tag, " R2 rx_en"},      {4'b0, rx_en},      {4'b0, erx});
        chk({tag, " R3 tx_drv_en"},  {4'b0, tx_drv_en},  {4'b0, etx});
        chk({tag, " R4 clk_drv_en"}, {4'b0, clk_drv_en}, {4'b0, eck});
        chk({tag, " R7 st_link"},    {4'b0, st_link},    {4'b0, est});
        chk({tag, " R5 tt_link"},    {4'b0, tt_link},    {4'b0, ett});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        do_reset();

        // R6: reset state at the read port and the pins
        rts = 4'b0101;
        bus_cycle(2'd0, 1'b0, 8'h00); chk("R6 byte0", bus_rdata, 8'h77);
        bus_cycle(2'd1, 1'b0, 8'h00); chk("R6 byte1", bus_rdata, 8'h77);
        bus_cycle(2'd2, 1'b0, 8'h00); chk("R6 byte2", bus_rdata, 8'h55);
        bus_cycle(2'd3, 1'b0, 8'h00); chk("R6 byte3", bus_rdata, 8'h00);
        chk_pins("R6 reset");

        // R1 R5 R9: table walk with write, readback and pin checks
        for (int k = 0; k < 10; k++) begin
            logic [25:0] v;
            v = VEC[k];
            rts = v[15:12];
            tclk_dir_out = v[11:8];
            bus_cycle(v[25:24], 1'b1, v[23:16]);
            chk($sformatf("R1 R9 row%0d readback", k), bus_rdata, v[7:0]);
            chk_pins($sformatf("row%0d", k));
        end

        // R8: flag stays after the cause is gone
        tclk_dir_out = 4'b0000;
        bus_cycle(2'd2, 1'b1, 8'h55);
        bus_cycle(2'd3, 1'b0, 8'h00);
        chk("R8 sticky", bus_rdata, 8'h80);

        // R10: read data follows only the registered address
        bus_addr = 2'd2;
        #3 chk("R10 before edge", bus_rdata, 8'h80);
        @(posedge clk); #3;
        chk("R10 after edge", bus_rdata, 8'h55);
        @(negedge clk);

        // R8 R9: reset clears the flag; a byte 3 write changes nothing
        do_reset();
        bus_cycle(2'd3, 1'b1, 8'hFF);
        chk("R9 R8 byte3 write ignored", bus_rdata, 8'h00);

        // R7: interlock reacts to direction with no clock edge
        bus_cycle(2'd2, 1'b1, 8'h00);
        chk_pins("R7 forward");
        chk("R7 forward both", {st_link, tt_link}, 8'hFF);
        tclk_dir_out = 4'b0001;
        #2 chk("R7 interlock", {4'b0, st_link}, 8'h0E);
        @(negedge clk);
        bus_cycle(2'd3, 1'b0, 8'h00);
        chk("R8 conflict set", bus_rdata, 8'h80);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule